// File: doc/BRIEF.md
# Alignment-Restartable Multiframe Clock Generator

This block keeps the local multiframe phase for a serial converter link. A free-running counter advances once per fabric clock and wraps after one multiframe. The fabric moves two octets per lane on each clock, so one multiframe lasts `floor(F*K/2)` clocks, where F is the number of octets per frame and K is the number of frames per multiframe. At phase zero the block raises a one-clock multiframe marker. Downstream logic uses the phase and the marker to release data at a fixed point in the multiframe.

For a repeatable link latency, the counter is pulled back to phase zero by an external alignment event. The event arrives asynchronously, so it passes through a synchronizer and a rising-edge detector first. The subclass setting picks the event source. Setting 1 uses the system reference input. Setting 2 uses the rising edge of the active-low link synchronization request, which occurs when the request is released. Setting 0 uses no event at all, and the counter simply free-runs from reset. A sticky flag reports that at least one alignment has occurred. An optional single-capture mode ignores every event after the first one.

Top module: `lmfc_align_gen`

## Requirements
- R1: With configured F octets per frame and K frames per multiframe, the phase output counts 0, 1, ... up to P-1 and then returns to 0, one step per clock, where P = floor(F*K/2). A P of 0 is treated as 1.
- R2: `lmfc_pulse` is 1 in exactly the cycles in which the phase output is 0.
- R3: With subclass 1, a low-to-high transition of `sysref_in` forces the phase to 0. The phase reads 0 after the third rising clock edge, counting from the edge that first samples the high level. Counting then continues from 0.
- R4: Only a low-to-high transition of the alignment input restarts the counter. A level held high, or a high-to-low transition, has no effect on the phase.
- R5: With subclass 2, a low-to-high transition of `sync_n_in` restarts the counter with the same three-edge timing as R3. With this setting `sysref_in` is ignored.
- R6: With subclass 1, `sync_n_in` is ignored. With subclass 0 (and with the unused code 3), both alignment inputs are ignored and the counter free-runs from reset.
- R7: `capture_done` goes to 1 on the same clock edge at which the first accepted restart forces the phase to 0. It then stays at 1 until reset.
- R8: With `cfg_single_capture` = 1, alignment edges after the first accepted restart are ignored. With it at 0, every qualifying edge restarts the counter.
- R9: While `rst_n` is low, the phase is 0, `lmfc_pulse` is 1 and `capture_done` is 0. On the first clock after release, the phase becomes 1 (when P > 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_subclass | input | 2 | Alignment source: 0 none, 1 system reference, 2 sync release |
| cfg_octets_per_frame | input | 5 | F, octets per frame |
| cfg_frames_per_mf | input | 6 | K, frames per multiframe |
| cfg_single_capture | input | 1 | 1: accept only the first alignment event |
| sysref_in | input | 1 | Asynchronous system reference |
| sync_n_in | input | 1 | Asynchronous active-low synchronization request |
| lmfc_phase | output | 8 | Current multiframe phase in clocks |
| lmfc_pulse | output | 1 | High while the phase is 0 |
| capture_done | output | 1 | Sticky: an alignment restart has occurred |

## Verification
The bench sweeps several F and K pairs, including odd products and the largest period. For each pair it fires alignment pulses at random offsets and widths and compares every cycle with an arithmetic model of the counter. A design with an extra or a missing synchronizer stage would reach zero one cycle early or late after every event. A level-triggered design would keep the phase pinned at zero while a long pulse is held high. A wrap off by one would show up as a period error at the largest or the odd-product settings. The bench also toggles the input that the current subclass should ignore, and repeats edges in single-capture mode. This catches a source selector that is swapped or missing, and a gate that fails to close after the first capture.

// File: rtl/lmfc_pkg.sv
package lmfc_pkg;
   typedef enum logic [1:0] {
      SC_FREE = 2'd0,
      SC_REF  = 2'd1,
      SC_SYNC = 2'd2,
      SC_RSVD = 2'd3
   } subclass_e;
endpackage

// File: rtl/lmfc_edge_sync.sv
module lmfc_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("lmfc_edge_sync: STAGES must be at least 2");
   end

   // chain[0..STAGES-1] synchronize, chain[STAGES] holds the previous level
   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], async_in};
   end

   assign rise_o = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/lmfc_period_calc.sv
module lmfc_period_calc #(
   parameter int F_W            = 5,
   parameter int K_W            = 6,
   parameter int PHASE_W        = 8,
   parameter int OCTETS_PER_CLK = 2
) (
   input  logic [F_W-1:0]     f_i,
   input  logic [K_W-1:0]     k_i,
   output logic [PHASE_W-1:0] term_o
);
   localparam int PROD_W = F_W + K_W;

   if (OCTETS_PER_CLK < 1) begin : g_bad_opc
      $error("lmfc_period_calc: OCTETS_PER_CLK must be positive");
   end

   logic [PROD_W-1:0] prod;
   logic [PROD_W-1:0] per;

   assign prod = PROD_W'(f_i) * PROD_W'(k_i);

   if ((OCTETS_PER_CLK & (OCTETS_PER_CLK - 1)) == 0) begin : g_shift
      assign per = prod >> $clog2(OCTETS_PER_CLK);
   end else begin : g_div
      assign per = prod / PROD_W'(OCTETS_PER_CLK);
   end

   always_comb begin
      if (per == '0) term_o = '0;
      else           term_o = PHASE_W'(per - PROD_W'(1));
   end
endmodule

// File: rtl/lmfc_phase_cnt.sv
module lmfc_phase_cnt #(
   parameter int PHASE_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               restart_i,
   input  logic [PHASE_W-1:0] term_i,
   output logic [PHASE_W-1:0] phase_o,
   output logic               zero_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                phase_o <= '0;
      else if (restart_i)        phase_o <= '0;
      else if (phase_o >= term_i) phase_o <= '0;
      else                       phase_o <= phase_o + PHASE_W'(1);
   end

   assign zero_o = (phase_o == '0);
endmodule

// File: rtl/lmfc_align_gen.sv
module lmfc_align_gen #(
   parameter int MAX_F          = 16,
   parameter int MAX_K          = 32,
   parameter int OCTETS_PER_CLK = 2,
   parameter int SYNC_STAGES    = 2,
   localparam int F_W        = $clog2(MAX_F + 1),
   localparam int K_W        = $clog2(MAX_K + 1),
   localparam int MAX_PERIOD = (MAX_F * MAX_K) / OCTETS_PER_CLK,
   localparam int PHASE_W    = (MAX_PERIOD > 1) ? $clog2(MAX_PERIOD) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         cfg_subclass,
   input  logic [F_W-1:0]     cfg_octets_per_frame,
   input  logic [K_W-1:0]     cfg_frames_per_mf,
   input  logic               cfg_single_capture,
   input  logic               sysref_in,
   input  logic               sync_n_in,
   output logic [PHASE_W-1:0] lmfc_phase,
   output logic               lmfc_pulse,
   output logic               capture_done
);
   import lmfc_pkg::*;

   if (MAX_F < 1 || MAX_K < 1) begin : g_bad_max
      $error("lmfc_align_gen: MAX_F and MAX_K must be positive");
   end

   logic               ref_rise;
   logic               syn_rise;
   logic               sel_rise;
   logic               restart;
   logic               done_q;
   logic [PHASE_W-1:0] term;
   subclass_e          sc;

   assign sc = subclass_e'(cfg_subclass);

   lmfc_edge_sync #(.STAGES(SYNC_STAGES)) ref_sync_i (
      .clk(clk), .rst_n(rst_n), .async_in(sysref_in), .rise_o(ref_rise)
   );

   lmfc_edge_sync #(.STAGES(SYNC_STAGES)) syn_sync_i (
      .clk(clk), .rst_n(rst_n), .async_in(sync_n_in), .rise_o(syn_rise)
   );

   always_comb begin
      unique case (sc)
         SC_REF:  sel_rise = ref_rise;
         SC_SYNC: sel_rise = syn_rise;
         default: sel_rise = 1'b0;
      endcase
   end

   assign restart = sel_rise & ~(cfg_single_capture & done_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       done_q <= 1'b0;
      else if (restart) done_q <= 1'b1;
   end

   lmfc_period_calc #(
      .F_W(F_W), .K_W(K_W), .PHASE_W(PHASE_W), .OCTETS_PER_CLK(OCTETS_PER_CLK)
   ) period_i (
      .f_i(cfg_octets_per_frame), .k_i(cfg_frames_per_mf), .term_o(term)
   );

   lmfc_phase_cnt #(.PHASE_W(PHASE_W)) cnt_i (
      .clk(clk), .rst_n(rst_n), .restart_i(restart), .term_i(term),
      .phase_o(lmfc_phase), .zero_o(lmfc_pulse)
   );

   assign capture_done = done_q;
endmodule

// File: rtl/lmfc_align_gen_chk.sv
module lmfc_align_gen_chk #(
   parameter int PHASE_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic [1:0]         cfg_subclass,
   input logic               cfg_single_capture,
   input logic               restart,
   input logic [PHASE_W-1:0] term,
   input logic [PHASE_W-1:0] lmfc_phase,
   input logic               lmfc_pulse,
   input logic               capture_done
);
   assert_phase_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      lmfc_phase <= term);

   assert_phase_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && lmfc_phase < term) |=> lmfc_phase == $past(lmfc_phase) + PHASE_W'(1));

   assert_phase_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && lmfc_phase == term) |=> lmfc_phase == '0);

   assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (lmfc_pulse && term != '0 && !restart) |=> !lmfc_pulse);

   assert_restart_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (lmfc_phase == '0 && capture_done));

   assert_no_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_subclass == 2'd0 || cfg_subclass == 2'd3) |-> !restart);

   assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(capture_done));

   assert_single_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_single_capture && capture_done) |-> !restart);
endmodule

bind lmfc_align_gen lmfc_align_gen_chk #(.PHASE_W(PHASE_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .cfg_subclass(cfg_subclass),
   .cfg_single_capture(cfg_single_capture), .restart(restart), .term(term),
   .lmfc_phase(lmfc_phase), .lmfc_pulse(lmfc_pulse), .capture_done(capture_done)
);

// File: tb/lmfc_align_gen_tb.sv
module lmfc_align_gen_tb_top;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cfg_subclass = 2'd1;
   logic [4:0] cfg_octets_per_frame = 5'd2;
   logic [5:0] cfg_frames_per_mf = 6'd32;
   logic       cfg_single_capture = 1'b0;
   logic       sysref_in = 1'b0;
   logic       sync_n_in = 1'b0;
   logic [7:0] lmfc_phase;
   logic       lmfc_pulse;
   logic       capture_done;

   always #(CLK_PERIOD / 2) clk = ~clk;

   lmfc_align_gen dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_subclass(cfg_subclass),
      .cfg_octets_per_frame(cfg_octets_per_frame), .cfg_frames_per_mf(cfg_frames_per_mf),
      .cfg_single_capture(cfg_single_capture), .sysref_in(sysref_in), .sync_n_in(sync_n_in),
      .lmfc_phase(lmfc_phase), .lmfc_pulse(lmfc_pulse), .capture_done(capture_done)
   );

   int vec_cnt = 0;
   int err_cnt = 0;
   int period = 32;

   // Model: restart when the level sampled two edges back is high and three back is low
   int       m_phase = 0;
   bit       m_done = 1'b0;
   bit [3:0] hr = '0;
   bit [3:0] hs = '0;

   always @(posedge clk) begin
      bit raw;
      if (!rst_n) begin
         m_phase = 0; m_done = 1'b0; hr = '0; hs = '0;
      end else begin
         hr = {hr[2:0], sysref_in};
         hs = {hs[2:0], sync_n_in};
         raw = (cfg_subclass == 2'd1) ? (hr[2] & ~hr[3]) :
               (cfg_subclass == 2'd2) ? (hs[2] & ~hs[3]) : 1'b0;
         if (raw && !(cfg_single_capture && m_done)) begin
            m_phase = 0; m_done = 1'b1;
         end else begin
            m_phase = (m_phase >= period - 1) ? 0 : m_phase + 1;
         end
      end
   end

   task automatic step(input string tag);
      @(negedge clk);
      vec_cnt++;
      if (lmfc_phase !== 8'(m_phase) || lmfc_pulse !== (m_phase == 0) ||
          capture_done !== m_done) begin
         err_cnt++;
         $display("FAIL %s: phase=%0d pulse=%0b done=%0b expected phase=%0d pulse=%0b done=%0b",
                  tag, lmfc_phase, lmfc_pulse, capture_done, m_phase, (m_phase == 0), m_done);
      end
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(tag);
   endtask

   task automatic apply_reset(input int sc, input int f, input int k, input bit once);
      @(negedge clk);
      rst_n = 1'b0;
      cfg_subclass = 2'(sc);
      cfg_octets_per_frame = 5'(f);
      cfg_frames_per_mf = 6'(k);
      cfg_single_capture = once;
      sysref_in = 1'b0;
      sync_n_in = 1'b0;
      period = (f * k) / 2;
      if (period < 1) period = 1;
      repeat (2) @(negedge clk);
      step("R9 reset state");
      rst_n = 1'b1;
      step("R9 first count");
   endtask

   task automatic ref_pulse(input int width, input string tag);
      sysref_in = 1'b1;
      idle(width, tag);
      sysref_in = 1'b0;
   endtask

   task automatic sync_release(input int low_len, input string tag);
      sync_n_in = 1'b0;
      idle(low_len, tag);
      sync_n_in = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      err_cnt++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
      $finish;
   end

   initial begin
      int fs[7] = '{1, 2, 4, 2, 4, 1, 16};
      int ks[7] = '{32, 32, 32, 9, 9, 9, 32};
      for (int c = 0; c < 7; c++) begin
         // R1 R2: free count before any event
         apply_reset(1, fs[c], ks[c], 1'b0);
         idle(2 * period + 3, "R1 R2 free count");
         // R3: short pulses at random offsets
         for (int p = 0; p < 4; p++) begin
            idle($urandom_range(0, period), "R3 gap");
            ref_pulse($urandom_range(1, 4), "R3 pulse");
            idle(period + 4, "R3 after edge");
         end
         // R4: long high level, then fall
         ref_pulse(period + 6, "R4 held high");
         idle(period + 4, "R4 after fall");
         // R6: sync toggles ignored in subclass 1
         sync_release(3, "R6 sync ignored");
         idle(period + 4, "R6 sync ignored");
         sync_n_in = 1'b0;
         idle(5, "R6 sync ignored");

         // R5: subclass 2 uses sync release, ignores sysref
         apply_reset(2, fs[c], ks[c], 1'b0);
         idle($urandom_range(1, period), "R5 sync low");
         sync_n_in = 1'b1;
         idle(period + 4, "R5 after release");
         ref_pulse(2, "R5 sysref ignored");
         idle(period + 4, "R5 sysref ignored");
         sync_release($urandom_range(1, 6), "R5 second request");
         idle(period + 4, "R5 second release");

         // R6: subclass 0 ignores both
         apply_reset(0, fs[c], ks[c], 1'b0);
         ref_pulse(3, "R6 free sysref");
         idle(4, "R6 free");
         sync_n_in = 1'b1;
         idle(period + 4, "R6 free sync");

         // R7 R8: single capture
         apply_reset(1, fs[c], ks[c], 1'b1);
         idle($urandom_range(2, period), "R7 before capture");
         ref_pulse(1, "R7 first edge");
         idle(period + 2, "R7 R8 captured");
         for (int p = 0; p < 3; p++) begin
            idle($urandom_range(0, period), "R8 gap");
            ref_pulse($urandom_range(1, 3), "R8 ignored edge");
         end
         idle(period + 4, "R8 ignored edges");
      end
      $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
      $finish;
   end
endmodule